// File: doc/BRIEF.md
# Sector Page Loader with Erase-and-Program Sequencer

This block gathers the write data for one 64-byte sector of a 32 KiB byte-wide non-volatile array. Once an unlock guard grants access, bytes are handed in one at a time: a start pulse carries the address and an end pulse carries the data. Bytes may come in any order, and each one that is accepted is kept in a local page buffer along with a per-byte loaded flag. The load window stays open while strobes keep arriving. It closes on its own after a programmable number of idle clock ticks.

When the window closes, the block turns busy and starts its internal cycle. It first writes FFh to all 64 locations of the sector through its storage write port, lowest byte first. It then writes only the bytes that were loaded. Busy stays high for a programmable number of cycles. Any byte of the sector that was not loaded is left at FFh. Strobes that arrive while busy are ignored, and so are strobes aimed at a different sector.

Top module: `sector_load_prog`

## Requirements
- R1: Address bit fields: bits 14..6 are the sector and bits 5..0 are the byte within the sector. Every storage write of a cycle goes to address {latched sector, byte index}, and no location outside that sector changes.
- R2: A load that starts while idle is accepted only if `unlock_i` is high. Without it, the strobe pair is ignored: busy stays low and the last-byte outputs keep their values.
- R3: The address is captured on a `ld_start_i` pulse and the data on the following `ld_end_i` pulse. `last_addr_o` and `last_data_o` show that byte from the cycle after the end pulse.
- R4: Bytes of a sector may be loaded in any order, and each one lands at its own byte address.
- R5: `busy_o` rises exactly WINDOW_TICKS clock edges after the last accepted strobe pulse. A new accepted strobe before then restarts the count.
- R6: A program cycle makes 64 FFh writes at ascending byte indices, then writes the loaded bytes only.
- R7: After a cycle, every byte of the sector that was not loaded holds FFh.
- R8: `busy_o` stays high for exactly PROG_TICKS cycles.
- R9: A start pulse whose sector field differs from the first load's sector field is ignored, together with its end pulse.
- R10: Strobes that arrive while `busy_o` is high are ignored: nothing is latched and no further cycle follows.
- R11: The loaded flags are cleared at the first load of each operation, so bytes loaded in an earlier operation are not written again.
- R12: After reset, busy, the write enable, the sector output and the last-byte outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unlock_i | input | 1 | Grant from the unlock guard; needed for the first load |
| ld_start_i | input | 1 | One-cycle pulse: capture the load address |
| ld_end_i | input | 1 | One-cycle pulse: capture the load data |
| ld_addr_i | input | 15 | Load address (sector in 14..6, byte in 5..0) |
| ld_data_i | input | 8 | Load data |
| busy_o | output | 1 | High during the erase-and-program cycle |
| sect_addr_o | output | 9 | Sector latched for the current operation |
| last_addr_o | output | 15 | Address of the last byte loaded |
| last_data_o | output | 8 | Value of the last byte loaded |
| mem_we_o | output | 1 | Storage write enable |
| mem_addr_o | output | 15 | Storage write address |
| mem_wdata_o | output | 8 | Storage write data |

## Verification
The hardest cases to reach are stale loaded flags and the edge of the load window. The bench runs a second operation on a sector that was programmed earlier and loads only one new byte, so any leftover flag would show up as a reprogrammed old byte instead of FFh. It also spaces loads just inside the window and counts edges after the last end pulse to find the exact cycle busy rises. A shadow copy of the storage, built from the write port, checks the erase-before-program order and the final sector contents.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_ERASE = 3'd2,
    ST_PROG  = 3'd3,
    ST_WAIT  = 3'd4
  } slp_state_e;

  function automatic logic is_busy(slp_state_e s);
    return (s == ST_ERASE) || (s == ST_PROG) || (s == ST_WAIT);
  endfunction
endpackage

// File: rtl/slp_tick_timer.sv
module slp_tick_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end  = (cnt_q == CNT_W'(LIMIT - 1));
  assign expired = run && !clear && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)
      cnt_d = '0;
    else if (run && !at_end)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/slp_page_buf.sv
module slp_page_buf #(
  parameter int DATA_W    = 8,
  parameter int BYTE_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_mask,
  input  logic                 wr_en,
  input  logic [BYTE_BITS-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [BYTE_BITS-1:0] rd_idx,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_loaded
);
  localparam int DEPTH = 1 << BYTE_BITS;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  mask_q, mask_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == BYTE_BITS'(g));
    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= wr_data;
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (clr_mask) mask_d = '0;
    if (wr_en)    mask_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign rd_data   = data_q[rd_idx];
  assign rd_loaded = mask_q[rd_idx];
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int BYTE_BITS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        unlock_i,
  input  logic                        ld_start_i,
  input  logic                        ld_end_i,
  input  logic [ADDR_W-1:0]           ld_addr_i,
  input  logic [DATA_W-1:0]           ld_data_i,
  input  logic                        win_expired,
  input  logic                        cyc_expired,
  output slp_state_e                  state_o,
  output logic [BYTE_BITS-1:0]        idx_o,
  output logic [ADDR_W-BYTE_BITS-1:0] sect_o,
  output logic [BYTE_BITS-1:0]        byte_o,
  output logic                        start_ok_o,
  output logic                        end_ok_o,
  output logic                        first_load_o,
  output logic [ADDR_W-1:0]           last_addr_o,
  output logic [DATA_W-1:0]           last_data_o
);
  localparam int SECT_W = ADDR_W - BYTE_BITS;
  localparam logic [BYTE_BITS-1:0] IDX_MAX = '1;

  slp_state_e              state_q, state_d;
  logic [BYTE_BITS-1:0]    idx_q, idx_d;
  logic [SECT_W-1:0]       sect_q, sect_d;
  logic [BYTE_BITS-1:0]    byte_q, byte_d;
  logic                    pend_q, pend_d;
  logic [ADDR_W-1:0]       laddr_q, laddr_d;
  logic [DATA_W-1:0]       ldata_q, ldata_d;
  logic                    start_ok, end_ok, first_load;
  logic [SECT_W-1:0]       in_sect;

  assign in_sect    = ld_addr_i[ADDR_W-1:BYTE_BITS];
  assign first_load = ld_start_i && (state_q == ST_IDLE) && unlock_i;
  assign start_ok   = first_load ||
                      (ld_start_i && (state_q == ST_LOAD) && (in_sect == sect_q));
  assign end_ok     = ld_end_i && pend_q && (state_q == ST_LOAD);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (first_load)         state_d = ST_LOAD;
      ST_LOAD:  if (win_expired)        state_d = ST_ERASE;
      ST_ERASE: if (idx_q == IDX_MAX)   state_d = ST_PROG;
      ST_PROG:  if (idx_q == IDX_MAX)   state_d = ST_WAIT;
      ST_WAIT:  if (cyc_expired)        state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    idx_d   = '0;
    if ((state_q == ST_ERASE) || (state_q == ST_PROG)) idx_d = idx_q + 1'b1;
    sect_d  = first_load ? in_sect : sect_q;
    byte_d  = start_ok ? ld_addr_i[BYTE_BITS-1:0] : byte_q;
    pend_d  = pend_q;
    if (start_ok)    pend_d = 1'b1;
    else if (end_ok) pend_d = 1'b0;
    if (win_expired) pend_d = 1'b0;
    laddr_d = end_ok ? {sect_q, byte_q} : laddr_q;
    ldata_d = end_ok ? ld_data_i : ldata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sect_q  <= '0;
      byte_q  <= '0;
      pend_q  <= 1'b0;
      laddr_q <= '0;
      ldata_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sect_q  <= sect_d;
      byte_q  <= byte_d;
      pend_q  <= pend_d;
      laddr_q <= laddr_d;
      ldata_q <= ldata_d;
    end
  end

  assign state_o      = state_q;
  assign idx_o        = idx_q;
  assign sect_o       = sect_q;
  assign byte_o       = byte_q;
  assign start_ok_o   = start_ok;
  assign end_ok_o     = end_ok;
  assign first_load_o = first_load;
  assign last_addr_o  = laddr_q;
  assign last_data_o  = ldata_q;
endmodule

// File: rtl/sector_load_prog.sv
module sector_load_prog
  import slp_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int BYTE_BITS    = 6,
  parameter int WINDOW_TICKS = 18750,
  parameter int PROG_TICKS   = 2500000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        unlock_i,
  input  logic                        ld_start_i,
  input  logic                        ld_end_i,
  input  logic [ADDR_W-1:0]           ld_addr_i,
  input  logic [DATA_W-1:0]           ld_data_i,
  output logic                        busy_o,
  output logic [ADDR_W-BYTE_BITS-1:0] sect_addr_o,
  output logic [ADDR_W-1:0]           last_addr_o,
  output logic [DATA_W-1:0]           last_data_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o
);
  localparam int SECT_W = ADDR_W - BYTE_BITS;

  slp_state_e           state;
  logic [BYTE_BITS-1:0] idx;
  logic [SECT_W-1:0]    sect;
  logic [BYTE_BITS-1:0] byte_sel;
  logic                 start_ok, end_ok, first_load;
  logic                 win_expired, cyc_expired;
  logic                 busy;
  logic [DATA_W-1:0]    buf_data;
  logic                 buf_loaded;

  slp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_BITS(BYTE_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .unlock_i(unlock_i),
    .ld_start_i(ld_start_i), .ld_end_i(ld_end_i),
    .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .win_expired(win_expired), .cyc_expired(cyc_expired),
    .state_o(state), .idx_o(idx), .sect_o(sect), .byte_o(byte_sel),
    .start_ok_o(start_ok), .end_ok_o(end_ok), .first_load_o(first_load),
    .last_addr_o(last_addr_o), .last_data_o(last_data_o)
  );

  assign busy = is_busy(state);

  slp_tick_timer #(.LIMIT(WINDOW_TICKS)) u_win (
    .clk(clk), .rst_n(rst_n),
    .clear(start_ok || end_ok || (state != ST_LOAD)),
    .run(state == ST_LOAD),
    .expired(win_expired)
  );

  slp_tick_timer #(.LIMIT(PROG_TICKS)) u_cyc (
    .clk(clk), .rst_n(rst_n),
    .clear(!busy),
    .run(busy),
    .expired(cyc_expired)
  );

  slp_page_buf #(.DATA_W(DATA_W), .BYTE_BITS(BYTE_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .clr_mask(first_load),
    .wr_en(end_ok), .wr_idx(byte_sel), .wr_data(ld_data_i),
    .rd_idx(idx), .rd_data(buf_data), .rd_loaded(buf_loaded)
  );

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = {sect, idx};
    mem_wdata_o = '1;
    if (state == ST_ERASE) begin
      mem_we_o = 1'b1;
    end else if (state == ST_PROG) begin
      mem_we_o    = buf_loaded;
      mem_wdata_o = buf_data;
    end
  end

  assign busy_o      = busy;
  assign sect_addr_o = sect;
endmodule

// File: rtl/slp_checker.sv
module slp_checker #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int BYTE_BITS = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ld_end_i,
  input logic                        busy_o,
  input logic [ADDR_W-BYTE_BITS-1:0] sect_addr_o,
  input logic [ADDR_W-1:0]           last_addr_o,
  input logic [DATA_W-1:0]           last_data_o,
  input logic                        mem_we_o,
  input logic [ADDR_W-1:0]           mem_addr_o
);
  a_r6_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  a_r1_write_in_sector: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:BYTE_BITS] == sect_addr_o));

  a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |->
      ($stable(last_addr_o) && $stable(last_data_o) && $stable(sect_addr_o)));

  a_r3_data_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_data_o) |-> $past(ld_end_i));

  a_r9_sector_held_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> $stable(sect_addr_o));
endmodule

bind sector_load_prog slp_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_BITS(BYTE_BITS)
) u_slp_checker (
  .clk(clk), .rst_n(rst_n), .ld_end_i(ld_end_i), .busy_o(busy_o),
  .sect_addr_o(sect_addr_o), .last_addr_o(last_addr_o),
  .last_data_o(last_data_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/sector_load_prog_bench.sv
module sector_load_prog_bench;
  localparam int W   = 20;
  localparam int P   = 200;
  localparam int MSZ = 32768;

  logic        clk, rst_n, unlock_i, ld_start_i, ld_end_i;
  logic [14:0] ld_addr_i;
  logic [7:0]  ld_data_i;
  logic        busy_o, mem_we_o;
  logic [8:0]  sect_addr_o;
  logic [14:0] last_addr_o, mem_addr_o;
  logic [7:0]  last_data_o, mem_wdata_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] shadow [MSZ];
  int wr_in_op;
  int erase_bad;

  sector_load_prog #(.WINDOW_TICKS(W), .PROG_TICKS(P)) u_sector_load_prog (
    .clk(clk), .rst_n(rst_n), .unlock_i(unlock_i),
    .ld_start_i(ld_start_i), .ld_end_i(ld_end_i),
    .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .busy_o(busy_o), .sect_addr_o(sect_addr_o),
    .last_addr_o(last_addr_o), .last_data_o(last_data_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!busy_o) wr_in_op <= 0;
    else if (mem_we_o) begin
      shadow[mem_addr_o] <= mem_wdata_o;
      if (wr_in_op < 64 &&
          (mem_wdata_o != 8'hFF || mem_addr_o[5:0] != 6'(wr_in_op)))
        erase_bad <= erase_bad + 1;
      wr_in_op <= wr_in_op + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_byte(logic [14:0] a, logic [7:0] d);
    @(negedge clk); ld_start_i = 1; ld_addr_i = a;
    @(negedge clk); ld_start_i = 0;
    @(negedge clk); ld_end_i = 1; ld_data_i = d;
    @(negedge clk); ld_end_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_cycle(output int busy_len);
    busy_len = 0;
    while (!busy_o) @(negedge clk);
    while (busy_o) begin busy_len++; @(negedge clk); end
  endtask

  task automatic t_reset;
    chk("R12 busy", busy_o, 0);
    chk("R12 we", mem_we_o, 0);
    chk("R12 sect", sect_addr_o, 0);
    chk("R12 last_addr", last_addr_o, 0);
    chk("R12 last_data", last_data_o, 0);
  endtask

  task automatic t_basic;
    int len;
    int bad;
    logic [7:0] exp;
    erase_bad = 0;
    unlock_i = 1;
    load_byte({9'd5, 6'd9}, 8'h3C);
    unlock_i = 0;
    chk("R3 last_data", last_data_o, 8'h3C);
    chk("R3 last_addr", last_addr_o, {9'd5, 6'd9});
    idle(W - 5);
    chk("R5 window held open", busy_o, 0);
    load_byte({9'd5, 6'd2}, 8'h11);
    idle(W - 5);
    load_byte({9'd5, 6'd40}, 8'h7E);
    idle(W - 1);
    chk("R5 not yet busy", busy_o, 0);
    idle(1);
    chk("R5 busy on time", busy_o, 1);
    run_cycle(len);
    chk("R8 busy length", len - 0, P);
    chk("R6 erase first ascending", erase_bad, 0);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      exp = (i == 9) ? 8'h3C : (i == 2) ? 8'h11 : (i == 40) ? 8'h7E : 8'hFF;
      if (shadow[{9'd5, 6'(i)}] !== exp) bad++;
    end
    chk("R4 R7 sector contents", bad, 0);
    chk("R1 neighbour untouched", shadow[{9'd4, 6'd63}], 8'hA5);
    chk("R1 next sector untouched", shadow[{9'd6, 6'd0}], 8'hA5);
  endtask

  task automatic t_other_sector;
    int len;
    unlock_i = 1;
    load_byte({9'd7, 6'd0}, 8'h12);
    unlock_i = 0;
    load_byte({9'd8, 6'd1}, 8'h34);
    chk("R9 last_addr kept", last_addr_o, {9'd7, 6'd0});
    chk("R9 last_data kept", last_data_o, 8'h12);
    run_cycle(len);
    chk("R9 foreign byte unwritten", shadow[{9'd8, 6'd1}], 8'hA5);
    chk("R9 own byte programmed", shadow[{9'd7, 6'd0}], 8'h12);
  endtask

  task automatic t_busy;
    int len;
    unlock_i = 1;
    load_byte({9'd3, 6'd5}, 8'h55);
    while (!busy_o) @(negedge clk);
    load_byte({9'd3, 6'd6}, 8'h66);
    load_byte({9'd3, 6'd5}, 8'h99);
    chk("R10 last_data while busy", last_data_o, 8'h55);
    run_cycle(len);
    unlock_i = 0;
    idle(W + 10);
    chk("R10 no second cycle", busy_o, 0);
    chk("R10 byte6 erased", shadow[{9'd3, 6'd6}], 8'hFF);
    chk("R10 byte5 kept", shadow[{9'd3, 6'd5}], 8'h55);
  endtask

  task automatic t_no_unlock;
    unlock_i = 0;
    load_byte({9'd9, 6'd3}, 8'hC3);
    idle(W + 10);
    chk("R2 no busy", busy_o, 0);
    chk("R2 last_data kept", last_data_o, 8'h55);
  endtask

  task automatic t_mask;
    int len;
    unlock_i = 1;
    load_byte({9'd7, 6'd10}, 8'h0A);
    unlock_i = 0;
    run_cycle(len);
    chk("R11 old byte not reprogrammed", shadow[{9'd7, 6'd0}], 8'hFF);
    chk("R11 new byte", shadow[{9'd7, 6'd10}], 8'h0A);
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) shadow[i] = 8'hA5;
    rst_n = 0; unlock_i = 0; ld_start_i = 0; ld_end_i = 0;
    ld_addr_i = '0; ld_data_i = '0;
    wr_in_op = 0; erase_bad = 0;
    idle(3);
    t_reset;
    rst_n = 1;
    idle(2);
    t_basic;
    t_other_sector;
    t_busy;
    t_no_unlock;
    t_mask;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule